// File: doc/BRIEF.md
# Baud clock generator

This block turns the system clock into slow, evenly spaced one-cycle clock enables for serial ports and timer channels. It has two independent channels. Each channel has a 2-bit prescaler, a 10-bit up-counter that reloads from a programmable 9-bit divide value with its top bit forced to one, and a 3-bit tap selector. The selector picks one counter bit, or bypasses the counter and takes the prescaler's half-rate bit. A rising edge on the chosen bit becomes a single-cycle enable.

Channel 0's enable is halved again to make a base rate that two UART clock enables share. Channel 1's enable drives three timer clock enables. A standby register can silence each downstream enable on its own. All settings are written through a small byte-wide write bus.

Top module: `baud_clkgen`

## Requirements
- R1: After reset, every output is low. With the reset register values (divide value 1FFh, prescaler code 00, tap code 000), no output produces a pulse.
- R2: Prescaler code 00 advances the counter on every cycle. Code 01 advances it on every 2nd cycle and code 10 on every 4th cycle. The prescaler code is in bits 3:2 of a channel's high control byte.
- R3: Register map. Channel c's low control byte is at address 2c and holds divide bits 7:0. Its high control byte is at address 2c+1 and holds divide bit 8 in bit 0. The counter loads {1, divide} and counts up to all ones, then reloads. When 512 minus the divide value is a multiple of 2^(k+1), tapping counter bit k gives one pulse every (prescale ratio × 2^(k+1)) cycles.
- R4: The tap code is in bits 6:4 of the high control byte. Codes 000, 001, 010, 011 and 100 select counter bits 6, 5, 4, 3 and 2. Code 110 selects bit 8 and code 111 selects bit 7.
- R5: Tap code 101 bypasses the counter. It pulses every 2 cycles, whatever the prescaler code is, including 11.
- R6: Prescaler code 11 freezes the counter. With any tap other than 101, the channel then produces no pulses.
- R7: A write to either control byte of a channel reloads that channel's counter on the next cycle. With prescaler code 00 and an aligned divide value, the first pulse is seen 1 + 2^k clock edges after the write edge.
- R8: Every channel enable is high for exactly one cycle at a time.
- R9: A UART enable only fires in a cycle where channel 0 pulses, and only on every second channel 0 pulse. Its spacing is therefore twice the channel 0 spacing.
- R10: The standby register is at address 4 and resets to 00h. Bit 0 silences UART enable 0 and bit 1 silences UART enable 1. Bits 5, 6 and 7 silence timer enables 0, 1 and 2, which otherwise follow channel 1's pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| ch0_tick | output | 1 | Channel 0 one-cycle enable |
| ch1_tick | output | 1 | Channel 1 one-cycle enable |
| uart_en | output | 2 | UART clock enables, derived from channel 0 at half rate |
| tmr_en | output | 3 | Timer clock enables, derived from channel 1 |

## Verification
A control-byte write can land in the same cycle the counter wraps to its load value, or the same cycle the selected tap rises. In that case the reload must win over the count step, and no stray pulse may slip out. The random part of the bench writes new settings at arbitrary phases of a running counter to provoke this. It then judges the outcome by the first-pulse delay after the write, which must equal 1 + 2^k edges whatever the phase was, and by the pulse spacing that follows.

// File: rtl/baud_clkgen_pkg.sv
package baud_clkgen_pkg;

    localparam int NUM_CH      = 2;
    localparam int DIV_W       = 9;
    localparam int CNT_W       = DIV_W + 1;
    localparam int TAP_W       = 3;
    localparam int PRE_W       = 2;
    localparam int ADDR_W      = 3;
    localparam int DATA_W      = 8;
    localparam int NUM_UART    = 2;
    localparam int NUM_TMR     = 3;
    localparam int IDX_W       = $clog2(CNT_W);
    localparam int UART_SRC    = 0;
    localparam int TMR_SRC     = 1;

    // bit positions inside the high control byte
    localparam int CTL_HI_BIT  = 0;
    localparam int CTL_PRE_LSB = 2;
    localparam int CTL_TAP_LSB = 4;
    // bit position of the first timer gate in the standby byte
    localparam int STBY_TMR_LSB = 5;

    localparam logic [ADDR_W-1:0] ADDR_STBY  = ADDR_W'(2 * NUM_CH);
    localparam logic [TAP_W-1:0]  TAP_BYPASS = 3'b101;
    localparam logic [DIV_W-1:0]  DIV_RST    = '1;

    typedef enum logic [PRE_W-1:0] {
        PRE_DIV1 = 2'b00,
        PRE_DIV2 = 2'b01,
        PRE_DIV4 = 2'b10,
        PRE_HALT = 2'b11
    } pre_mode_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        pre_mode_e        pre;
        logic [TAP_W-1:0] tap;
    } ch_cfg_t;

    // counter bit picked by a tap code (bypass code handled by caller)
    function automatic logic [IDX_W-1:0] tap_index(input logic [TAP_W-1:0] code);
        case (code)
            3'b000:  return IDX_W'(6);
            3'b001:  return IDX_W'(5);
            3'b010:  return IDX_W'(4);
            3'b011:  return IDX_W'(3);
            3'b100:  return IDX_W'(2);
            3'b110:  return IDX_W'(8);
            3'b111:  return IDX_W'(7);
            default: return IDX_W'(0);
        endcase
    endfunction

    // prescaler step qualifier from the free-running phase counter
    function automatic logic pre_fire(input pre_mode_e m, input logic [PRE_W-1:0] ph);
        case (m)
            PRE_DIV1: return 1'b1;
            PRE_DIV2: return ph[0];
            PRE_DIV4: return &ph;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/baud_regs.sv
module baud_regs
    import baud_clkgen_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output ch_cfg_t [NUM_CH-1:0]       cfg,
    output logic [NUM_CH-1:0]          reload,
    output logic [NUM_UART-1:0]        stby_uart,
    output logic [NUM_TMR-1:0]         stby_tmr
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(2 * c);
        localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(2 * c + 1);

        ch_cfg_t cfg_q;
        logic    reload_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q    <= '{div: DIV_RST, pre: PRE_DIV1, tap: '0};
                reload_q <= 1'b0;
            end else begin
                reload_q <= wr && ((addr == A_LO) || (addr == A_HI));
                if (wr && (addr == A_LO)) begin
                    cfg_q.div[DATA_W-1:0] <= wdata;
                end
                if (wr && (addr == A_HI)) begin
                    cfg_q.div[DIV_W-1] <= wdata[CTL_HI_BIT];
                    cfg_q.pre          <= pre_mode_e'(wdata[CTL_PRE_LSB +: PRE_W]);
                    cfg_q.tap          <= wdata[CTL_TAP_LSB +: TAP_W];
                end
            end
        end

        assign cfg[c]    = cfg_q;
        assign reload[c] = reload_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stby_uart <= '0;
            stby_tmr  <= '0;
        end else if (wr && (addr == ADDR_STBY)) begin
            stby_uart <= wdata[NUM_UART-1:0];
            stby_tmr  <= wdata[STBY_TMR_LSB +: NUM_TMR];
        end
    end

endmodule

// File: rtl/baud_channel.sv
module baud_channel
    import baud_clkgen_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ch_cfg_t cfg,
    input  logic    reload,
    output logic    tick
);

    logic [PRE_W-1:0] ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    logic             step;
    logic             tap_w;
    logic             prev_q;

    assign load_val = {1'b1, cfg.div};
    assign step     = pre_fire(cfg.pre, ph_q);

    always_comb begin
        if (cfg.tap == TAP_BYPASS) begin
            tap_w = ph_q[0];
        end else begin
            tap_w = cnt_q[tap_index(cfg.tap)];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            cnt_q  <= {1'b1, DIV_RST};
            prev_q <= 1'b1;
        end else begin
            ph_q   <= ph_q + 2'd1;
            prev_q <= tap_w;
            if (reload) begin
                cnt_q <= load_val;
            end else if (step) begin
                cnt_q <= (&cnt_q) ? load_val : cnt_q + 1'b1;
            end
        end
    end

    assign tick = tap_w & ~prev_q;

endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen
    import baud_clkgen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic        ch0_tick,
    output logic        ch1_tick,
    output logic [1:0]  uart_en,
    output logic [2:0]  tmr_en
);

    ch_cfg_t [NUM_CH-1:0]   cfg_all;
    logic [NUM_CH-1:0]      reload_all;
    logic [NUM_CH-1:0]      tick_all;
    logic [NUM_UART-1:0]    stby_uart_q;
    logic [NUM_TMR-1:0]     stby_tmr_q;
    logic                   uart_ph_q;
    logic                   uart_base;

    baud_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .cfg       (cfg_all),
        .reload    (reload_all),
        .stby_uart (stby_uart_q),
        .stby_tmr  (stby_tmr_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        baud_channel u_ch (
            .clk    (clk),
            .rst    (rst),
            .cfg    (cfg_all[c]),
            .reload (reload_all[c]),
            .tick   (tick_all[c])
        );
    end

    assign ch0_tick = tick_all[0];
    assign ch1_tick = tick_all[1];

    // halve the UART source so the serial ports see every second pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            uart_ph_q <= 1'b0;
        end else if (tick_all[UART_SRC]) begin
            uart_ph_q <= ~uart_ph_q;
        end
    end

    assign uart_base = tick_all[UART_SRC] & uart_ph_q;

    for (genvar u = 0; u < NUM_UART; u++) begin : g_uart
        assign uart_en[u] = uart_base & ~stby_uart_q[u];
    end

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        assign tmr_en[t] = tick_all[TMR_SRC] & ~stby_tmr_q[t];
    end

endmodule

// File: rtl/baud_clkgen_chk.sv
module baud_clkgen_chk
    import baud_clkgen_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic       ch0_tick,
    input logic       ch1_tick,
    input logic [1:0] uart_en,
    input logic [2:0] tmr_en,
    input logic [1:0] stby_uart,
    input logic [2:0] stby_tmr,
    input ch_cfg_t    cfg0
);

    logic wr_ch0;
    assign wr_ch0 = reg_wr && (reg_addr[2:1] == 2'b00);

    assert_ch0_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        ch0_tick |=> !ch0_tick);

    assert_ch1_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        ch1_tick |=> !ch1_tick);

    assert_uart_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
        (|uart_en) |-> ch0_tick);

    assert_uart_gated_R10: assert property (@(posedge clk) disable iff (rst)
        ((uart_en & stby_uart) == 2'b00));

    assert_tmr_on_tick_R10: assert property (@(posedge clk) disable iff (rst)
        (|tmr_en) |-> (ch1_tick && ((tmr_en & stby_tmr) == 3'b000)));

    assert_bypass_alternates_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg0.tap == TAP_BYPASS && $past(cfg0.tap) == TAP_BYPASS
         && $past(cfg0.tap, 2) == TAP_BYPASS) |-> (ch0_tick != $past(ch0_tick)));

    assert_halt_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg0.pre == PRE_HALT && cfg0.tap != TAP_BYPASS && $past(cfg0) == cfg0
         && !$past(wr_ch0, 2)) |-> !ch0_tick);

endmodule

bind baud_clkgen baud_clkgen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .ch0_tick  (ch0_tick),
    .ch1_tick  (ch1_tick),
    .uart_en   (uart_en),
    .tmr_en    (tmr_en),
    .stby_uart (stby_uart_q),
    .stby_tmr  (stby_tmr_q),
    .cfg0      (cfg_all[0])
);

// File: tb/baud_clkgen_tb.sv
module baud_clkgen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       ch0_tick;
    logic       ch1_tick;
    logic [1:0] uart_en;
    logic [2:0] tmr_en;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    baud_clkgen u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ch0_tick  (ch0_tick),
        .ch1_tick  (ch1_tick),
        .uart_en   (uart_en),
        .tmr_en    (tmr_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic get_sig(input int w);
        case (w)
            0: return ch0_tick;
            1: return ch1_tick;
            2: return uart_en[0];
            3: return uart_en[1];
            4: return tmr_en[0];
            5: return tmr_en[1];
            6: return tmr_en[2];
            default: return 1'b0;
        endcase
    endfunction

    // counter bit named by a tap code (R4)
    function automatic int tap_of(input int code);
        case (code)
            0: return 6;
            1: return 5;
            2: return 4;
            3: return 3;
            4: return 2;
            6: return 8;
            7: return 7;
            default: return -1;
        endcase
    endfunction

    function automatic int pre_ratio(input int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : 4;
    endfunction

    task automatic wr_reg(input int a, input int d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = 3'(a);
        reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic cfg_ch(input int ch, input int n, input int pre, input int tap);
        wr_reg(2 * ch, n & 8'hFF);
        wr_reg(2 * ch + 1, ((tap & 7) << 4) | ((pre & 3) << 2) | ((n >> 8) & 1));
    endtask

    // edges until the signal is seen high at a falling edge, or -1
    task automatic wait_pulse(input int w, input int limit, output int n);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (get_sig(w)) return;
            if (n >= limit) begin
                n = -1;
                return;
            end
        end
    endtask

    task automatic count_pulses(input int w, input int cycles, output int cnt);
        cnt = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (get_sig(w)) cnt++;
        end
    endtask

    task automatic check_spacing(input int w, input int exp, input string req);
        int n;
        wait_pulse(w, 2 * exp + 20, n);
        for (int r = 0; r < 2; r++) begin
            wait_pulse(w, exp + 20, n);
            check(n == exp, req, n, exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int n;
        int cnt;
        int bad;
        void'($urandom(32'h0000_5eed));

        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        check({ch0_tick, ch1_tick, uart_en, tmr_en} == 7'd0, "R1 outputs low", 
              int'({ch0_tick, ch1_tick, uart_en, tmr_en}), 0);
        bad = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if ({ch0_tick, ch1_tick, uart_en, tmr_en} != 7'd0) bad++;
        end
        check(bad == 0, "R1 no pulses from reset settings", bad, 0);

        // R3 R4: tap bit 2, divide 1F8h, ratio 1 -> 8 cycles
        cfg_ch(0, 'h1F8, 0, 4);
        check_spacing(0, 8, "R3 R4 tap code 100 spacing");
        // R8: pulse lasts one cycle
        wait_pulse(0, 40, n);
        @(negedge clk);
        check(ch0_tick == 1'b0, "R8 one-cycle pulse", int'(ch0_tick), 0);

        // R3 R4: tap bit 7 with divide 100h -> 256
        cfg_ch(1, 'h100, 0, 7);
        check_spacing(1, 256, "R3 R4 tap code 111 spacing");
        // R2 R4: tap bit 8, divide 0, prescaler code 01 -> 1024
        cfg_ch(1, 'h000, 1, 6);
        check_spacing(1, 1024, "R2 R4 tap code 110 prescale 2");

        // R7: reload after a high-byte write, tap bit 3, divide 1F0h
        cfg_ch(0, 'h1F0, 0, 3);
        wait_pulse(0, 40, n);
        check(n > 0, "R7 settles", n, 1);
        wr_reg(1, (3 << 4) | 1);
        wait_pulse(0, 100, n);
        check(n == 9, "R7 first pulse after high-byte write", n, 9);
        // R7: low-byte write alone reloads too (divide becomes 1E0h)
        wr_reg(0, 'hE0);
        wait_pulse(0, 100, n);
        check(n == 9, "R7 first pulse after low-byte write", n, 9);
        check_spacing(0, 16, "R3 spacing after low-byte update");

        // R5: bypass code 101 ignores the prescaler, even code 11
        cfg_ch(0, 'h1F8, 0, 5);
        check_spacing(0, 2, "R5 bypass prescale 1");
        cfg_ch(0, 'h1F8, 3, 5);
        check_spacing(0, 2, "R5 bypass prescale halt");

        // R6: prescaler code 11 with a counter tap stays silent
        cfg_ch(1, 'h180, 3, 0);
        repeat (3) @(negedge clk);
        count_pulses(1, 2000, cnt);
        check(cnt == 0, "R6 halted channel pulses", cnt, 0);

        // R9: UART enables at half the channel 0 rate, coincident with it
        cfg_ch(0, 'h1F8, 0, 4);
        check_spacing(3, 16, "R9 UART enable spacing");
        bad = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if ((|uart_en) && !ch0_tick) bad++;
        end
        check(bad == 0, "R9 UART enable without channel 0 pulse", bad, 0);

        // R10: standby bit 0 silences UART 0 only
        wr_reg(4, 'h01);
        count_pulses(2, 200, cnt);
        check(cnt == 0, "R10 UART 0 in standby", cnt, 0);
        check_spacing(3, 16, "R10 UART 1 still running");
        // R10: standby bit 6 silences timer 1 only
        cfg_ch(1, 'h1F8, 0, 4);
        wr_reg(4, 'h40);
        count_pulses(5, 200, cnt);
        check(cnt == 0, "R10 timer 1 in standby", cnt, 0);
        check_spacing(4, 8, "R10 timer 0 follows channel 1");
        check_spacing(6, 8, "R10 timer 2 follows channel 1");
        wr_reg(4, 'h00);
        check_spacing(5, 8, "R10 timer 1 released");

        // R2 R3 R4 R7: random settings written at arbitrary counter phases
        for (int it = 0; it < 12; it++) begin
            int ch;
            int code;
            int k;
            int pre;
            int m;
            int p;
            int exp;
            ch = int'($urandom % 2);
            code = int'($urandom % 7);
            if (code >= 5) code = code + 1;
            k = tap_of(code);
            pre = int'($urandom % 3);
            m = 1 + int'($urandom % (512 >> (k + 1)));
            p = m << (k + 1);
            exp = pre_ratio(pre) << (k + 1);
            repeat (int'($urandom % 37)) @(negedge clk);
            cfg_ch(ch, 512 - p, pre, code);
            if (pre == 0) begin
                wait_pulse(ch, 1100, n);
                check(n == 1 + (1 << k), "R7 random first pulse", n, 1 + (1 << k));
            end
            check_spacing(ch, exp, "R2 R3 random spacing");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule